// File: doc/BRIEF.md
# Serial Flash Command Front End

This block is the slave-side serial engine of a serial flash device. It runs on the chip clock and oversamples a synchronized SPI slave port that works in clock modes 0 and 3. It captures an 8-bit opcode and a 24-bit address, shifts read data, status, identity and signature bytes out on the serial output, and tracks a deep power-down state. Program, erase and status-write frames are not executed here. When the frame closes, they are handed to a separate protection controller as a one-cycle request that carries an operation code, the captured address and the frame's byte count.

Whether a command takes effect depends on more than its opcode. It also depends on the number of bits clocked before chip select rises, on the deep power-down state, and on a busy flag from the protection controller. The busy flag is taken at the eighth bit of the frame. The memory array is modelled by a small register file that sits at the bottom of the address space. Every byte above that window reads as erased (FFh). A side port loads the register file.

Top module: `flash_fe`

## Requirements
- R1: SI is sampled on each rising SCK while CS# is low, and SO changes on each falling SCK. Both opcode and data move most-significant bit first. Clock modes 0 (SCK idles low) and 3 (SCK idles high) give identical results.
- R2: Opcode 03h takes a 24-bit address. Data bytes then stream from the next byte onward, with the address incrementing, until CS# rises. Address bits above the array width are dropped, and the address wraps from 3FFFFFh to 000000h. Bytes at or above 2^MEM_AW read FFh.
- R3: Opcode 0Bh behaves like 03h, except that one dummy byte comes between the address and the first data byte.
- R4: Opcode 05h returns status_i in every byte after the opcode. It works while busy and is ignored in deep power-down.
- R5: Opcode 9Fh returns 01h, 02h and 15h, in that order, in the three bytes after the opcode.
- R6: Opcode ABh returns 15h in every byte after the opcode and three dummy bytes. It works in deep power-down, and deep power-down ends when CS# rises. If busy, it produces no output and deep power-down is left unchanged.
- R7: Opcode B9h sets deep power-down when CS# rises, but only after a nonzero whole number of bytes. While deep power-down is set, every opcode other than ABh is ignored.
- R8: Six opcodes raise wr_req_o for exactly one cycle after CS# rises, and only when the frame's bit count is a nonzero multiple of 8. The opcodes and their wr_op_o codes are 06h→0, 04h→1, 01h→2, 02h→3, D8h→4 and C7h→5. wr_addr_o carries address bytes 2–4 and wr_bytes_o carries the byte count.
- R9: If busy_i is high at the eighth bit, opcodes 03h, 0Bh, 9Fh, B9h and the six write-class opcodes have no effect.
- R10: so_oe_o is low while CS# is high and during the opcode, address and dummy bytes.
- R11: After reset, so_oe_o, wr_req_o and dp_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Chip clock, oversamples the serial port |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sck_i | input | 1 | Serial clock, already synchronized |
| cs_ni | input | 1 | Active-low chip select, already synchronized |
| si_i | input | 1 | Serial data in |
| so_o | output | 1 | Serial data out |
| so_oe_o | output | 1 | Output enable for so_o |
| busy_i | input | 1 | Write, program or erase in progress |
| status_i | input | 8 | Status byte returned by opcode 05h |
| dp_o | output | 1 | Deep power-down state |
| wr_req_o | output | 1 | One-cycle write-class request |
| wr_op_o | output | 3 | Request operation code |
| wr_addr_o | output | ARRAY_AW | Captured array address |
| wr_bytes_o | output | CNT_W-3 | Bytes in the requesting frame |
| ld_en_i | input | 1 | Register-file load strobe |
| ld_addr_i | input | MEM_AW | Register-file load address |
| ld_data_i | input | 8 | Register-file load data |

## Verification
The hardest state to reach is a signature frame that arrives while deep power-down is set and busy is also high. The stimulus first enters deep power-down with a clean B9h frame. It then raises busy and sends ABh, and it expects no output and no exit. It repeats the ABh frame with busy low and expects the signature bytes and the exit. The other conditions that depend on bit count and mode come from frames that stop one bit past a byte boundary, from short 8-bit frames, and from reads that start two bytes below the top of the array, all sent in both SCK idle levels.

// File: rtl/flash_fe_pkg.sv
package flash_fe_pkg;
  localparam logic [7:0] OPC_READ = 8'h03;
  localparam logic [7:0] OPC_FAST = 8'h0B;
  localparam logic [7:0] OPC_RDSR = 8'h05;
  localparam logic [7:0] OPC_RDID = 8'h9F;
  localparam logic [7:0] OPC_SIG  = 8'hAB;
  localparam logic [7:0] OPC_DP   = 8'hB9;
  localparam logic [7:0] OPC_WREN = 8'h06;
  localparam logic [7:0] OPC_WRDI = 8'h04;
  localparam logic [7:0] OPC_WRSR = 8'h01;
  localparam logic [7:0] OPC_PP   = 8'h02;
  localparam logic [7:0] OPC_SE   = 8'hD8;
  localparam logic [7:0] OPC_BE   = 8'hC7;

  typedef enum logic [2:0] {
    WOP_WREN = 3'd0, WOP_WRDI = 3'd1, WOP_WRSR = 3'd2,
    WOP_PP   = 3'd3, WOP_SE   = 3'd4, WOP_BE   = 3'd5
  } wr_op_e;
endpackage

// File: rtl/flash_fe_rx.sv
module flash_fe_rx #(
  parameter int CNT_W    = 12,
  parameter int ADDR_W   = 24,
  parameter int ARRAY_AW = 22
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                sck_i,
  input  logic                cs_ni,
  input  logic                si_i,
  output logic                sck_fall_o,
  output logic                frame_end_o,
  output logic                opc_stb_o,
  output logic [7:0]          opc_next_o,
  output logic [7:0]          opcode_o,
  output logic [ARRAY_AW-1:0] addr_o,
  output logic [CNT_W-1:0]    bit_cnt_o
);
  localparam int ADDR_LAST = ADDR_W + 7;

  logic                sck_q, cs_q, sck_rise;
  logic [ARRAY_AW-2:0] sreg_q;
  logic [CNT_W-1:0]    cnt_q;

  assign sck_rise    = sck_i & ~sck_q & ~cs_ni;
  assign sck_fall_o  = ~sck_i & sck_q & ~cs_ni;
  assign frame_end_o = cs_ni & ~cs_q;
  assign opc_next_o  = {sreg_q[6:0], si_i};
  assign opc_stb_o   = sck_rise && (cnt_q == CNT_W'(7));
  assign bit_cnt_o   = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_q    <= 1'b0;
      cs_q     <= 1'b1;
      sreg_q   <= '0;
      cnt_q    <= '0;
      opcode_o <= '0;
      addr_o   <= '0;
    end else begin
      sck_q <= sck_i;
      cs_q  <= cs_ni;
      if (cs_ni) begin
        cnt_q <= '0;
      end else if (sck_rise) begin
        sreg_q <= {sreg_q[ARRAY_AW-3:0], si_i};
        if (cnt_q != '1) cnt_q <= cnt_q + 1'b1;
        if (cnt_q == CNT_W'(7)) opcode_o <= opc_next_o;
        // upper address bits fall off the shifter: array is 2^ARRAY_AW bytes
        if (cnt_q == CNT_W'(ADDR_LAST)) addr_o <= {sreg_q, si_i};
      end
    end
  end
endmodule

// File: rtl/flash_fe_mem.sv
module flash_fe_mem #(
  parameter int MEM_AW   = 6,
  parameter int ARRAY_AW = 22
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                ld_en_i,
  input  logic [MEM_AW-1:0]   ld_addr_i,
  input  logic [7:0]          ld_data_i,
  input  logic [ARRAY_AW-1:0] rd_addr_i,
  output logic [7:0]          rd_data_o
);
  localparam int DEPTH = 1 << MEM_AW;

  logic [7:0] row_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int r = 0; r < DEPTH; r++) row_q[r] <= 8'hFF;
    end else if (ld_en_i) begin
      row_q[ld_addr_i] <= ld_data_i;
    end
  end

  // populated window at the array base, erased above it
  assign rd_data_o = ((rd_addr_i >> MEM_AW) == '0) ? row_q[rd_addr_i[MEM_AW-1:0]] : 8'hFF;
endmodule

// File: rtl/flash_fe_ctrl.sv
module flash_fe_ctrl
  import flash_fe_pkg::*;
#(
  parameter int         CNT_W    = 12,
  parameter int         ARRAY_AW = 22,
  parameter logic [7:0] MFR_ID   = 8'h01,
  parameter logic [7:0] TYPE_ID  = 8'h02,
  parameter logic [7:0] CAP_ID   = 8'h15,
  parameter logic [7:0] SIG_ID   = 8'h15
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cs_ni,
  input  logic                busy_i,
  input  logic [7:0]          status_i,
  input  logic                sck_fall_i,
  input  logic                frame_end_i,
  input  logic                opc_stb_i,
  input  logic [7:0]          opc_next_i,
  input  logic [7:0]          opcode_i,
  input  logic [ARRAY_AW-1:0] addr_i,
  input  logic [CNT_W-1:0]    bit_cnt_i,
  input  logic [7:0]          rd_data_i,
  output logic [ARRAY_AW-1:0] rd_addr_o,
  output logic                so_o,
  output logic                so_oe_o,
  output logic                dp_o,
  output logic                wr_req_o,
  output logic [2:0]          wr_op_o,
  output logic [ARRAY_AW-1:0] wr_addr_o,
  output logic [CNT_W-4:0]    wr_bytes_o
);
  localparam int KW = CNT_W - 3;

  logic          ok_q;
  logic [KW-1:0] k, skip;
  logic [2:0]    b;
  logic          tx_en, is_wr;
  logic [7:0]    tx_byte;
  wr_op_e        wop;

  function automatic logic allowed(input logic [7:0] op, input logic dp, input logic busy);
    case (op)
      OPC_SIG:  return !busy;
      OPC_RDSR: return !dp;
      default:  return !dp && !busy;
    endcase
  endfunction

  assign k         = bit_cnt_i[CNT_W-1:3];
  assign b         = bit_cnt_i[2:0];
  assign skip      = (opcode_i == OPC_FAST) ? KW'(5) : KW'(4);
  assign rd_addr_o = addr_i + ARRAY_AW'(k - skip);

  always_comb begin
    tx_en   = 1'b0;
    tx_byte = 8'h00;
    case (opcode_i)
      OPC_READ, OPC_FAST: begin tx_en = (k >= skip); tx_byte = rd_data_i; end
      OPC_RDSR:           begin tx_en = (k >= KW'(1)); tx_byte = status_i; end
      OPC_SIG:            begin tx_en = (k >= KW'(4)); tx_byte = SIG_ID; end
      OPC_RDID: begin
        tx_en = (k >= KW'(1)) && (k <= KW'(3));
        tx_byte = (k == KW'(1)) ? MFR_ID : (k == KW'(2)) ? TYPE_ID : CAP_ID;
      end
      default: ;
    endcase
    tx_en = tx_en & ok_q;
  end

  always_comb begin
    is_wr = 1'b1;
    wop   = WOP_WREN;
    case (opcode_i)
      OPC_WREN: wop = WOP_WREN;
      OPC_WRDI: wop = WOP_WRDI;
      OPC_WRSR: wop = WOP_WRSR;
      OPC_PP:   wop = WOP_PP;
      OPC_SE:   wop = WOP_SE;
      OPC_BE:   wop = WOP_BE;
      default:  is_wr = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ok_q       <= 1'b0;
      dp_o       <= 1'b0;
      so_o       <= 1'b0;
      so_oe_o    <= 1'b0;
      wr_req_o   <= 1'b0;
      wr_op_o    <= '0;
      wr_addr_o  <= '0;
      wr_bytes_o <= '0;
    end else begin
      wr_req_o <= 1'b0;
      if (opc_stb_i) ok_q <= allowed(opc_next_i, dp_o, busy_i);
      if (frame_end_i) begin
        ok_q <= 1'b0;
        // ok_q only set once a full opcode arrived, so bit_cnt_i >= 8 here
        if (ok_q && b == 3'd0) begin
          if (is_wr) begin
            wr_req_o   <= 1'b1;
            wr_op_o    <= wop;
            wr_addr_o  <= addr_i;
            wr_bytes_o <= k;
          end
          if (opcode_i == OPC_DP) dp_o <= 1'b1;
        end
        if (ok_q && opcode_i == OPC_SIG) dp_o <= 1'b0;
      end
      if (cs_ni) begin
        so_oe_o <= 1'b0;
      end else if (sck_fall_i) begin
        so_oe_o <= tx_en;
        so_o    <= tx_byte[~b];
      end
    end
  end
endmodule

// File: rtl/flash_fe.sv
module flash_fe #(
  parameter int CNT_W    = 12,
  parameter int ADDR_W   = 24,
  parameter int ARRAY_AW = 22,
  parameter int MEM_AW   = 6
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                sck_i,
  input  logic                cs_ni,
  input  logic                si_i,
  output logic                so_o,
  output logic                so_oe_o,
  input  logic                busy_i,
  input  logic [7:0]          status_i,
  output logic                dp_o,
  output logic                wr_req_o,
  output logic [2:0]          wr_op_o,
  output logic [ARRAY_AW-1:0] wr_addr_o,
  output logic [CNT_W-4:0]    wr_bytes_o,
  input  logic                ld_en_i,
  input  logic [MEM_AW-1:0]   ld_addr_i,
  input  logic [7:0]          ld_data_i
);
  logic                sck_fall, frame_end, opc_stb;
  logic [7:0]          opc_next, opcode, rd_data;
  logic [ARRAY_AW-1:0] addr, rd_addr;
  logic [CNT_W-1:0]    bit_cnt;

  flash_fe_rx #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .ARRAY_AW(ARRAY_AW)) u_rx (
    .clk_i, .rst_ni, .sck_i, .cs_ni, .si_i,
    .sck_fall_o(sck_fall), .frame_end_o(frame_end), .opc_stb_o(opc_stb),
    .opc_next_o(opc_next), .opcode_o(opcode), .addr_o(addr), .bit_cnt_o(bit_cnt)
  );

  flash_fe_mem #(.MEM_AW(MEM_AW), .ARRAY_AW(ARRAY_AW)) u_mem (
    .clk_i, .rst_ni, .ld_en_i, .ld_addr_i, .ld_data_i,
    .rd_addr_i(rd_addr), .rd_data_o(rd_data)
  );

  flash_fe_ctrl #(.CNT_W(CNT_W), .ARRAY_AW(ARRAY_AW)) u_ctrl (
    .clk_i, .rst_ni, .cs_ni, .busy_i, .status_i,
    .sck_fall_i(sck_fall), .frame_end_i(frame_end), .opc_stb_i(opc_stb),
    .opc_next_i(opc_next), .opcode_i(opcode), .addr_i(addr), .bit_cnt_i(bit_cnt),
    .rd_data_i(rd_data), .rd_addr_o(rd_addr),
    .so_o, .so_oe_o, .dp_o, .wr_req_o, .wr_op_o, .wr_addr_o, .wr_bytes_o
  );
endmodule

// File: rtl/flash_fe_chk.sv
module flash_fe_chk #(
  parameter int CNT_W = 12
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cs_ni,
  input logic             so_oe_o,
  input logic             dp_o,
  input logic             wr_req_o,
  input logic [CNT_W-4:0] wr_bytes_o
);
  // R10
  oe_off_deselected_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni |=> !so_oe_o);
  // R8
  req_after_cs_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_req_o |-> ($past(cs_ni) && wr_bytes_o != '0));
  // R8
  req_one_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_req_o |=> !wr_req_o);
  // R7
  dp_enter_on_cs_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dp_o) |-> $past(cs_ni));
  // R6
  dp_leave_on_cs_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(dp_o) |-> $past(cs_ni));
  // R7
  no_req_in_dp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_req_o |-> !dp_o);
endmodule

bind flash_fe flash_fe_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i, .rst_ni, .cs_ni, .so_oe_o, .dp_o, .wr_req_o, .wr_bytes_o
);

// File: tb/flash_fe_test.sv
module flash_fe_test;
  localparam int CNT_W = 12, ARRAY_AW = 22, MEM_AW = 6;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic sck = 1'b0, cs_n = 1'b1, si = 1'b0, busy = 1'b0;
  logic so_o, so_oe_o, dp_o, wr_req_o;
  logic [2:0] wr_op_o;
  logic [ARRAY_AW-1:0] wr_addr_o;
  logic [CNT_W-4:0] wr_bytes_o;
  logic ld_en = 1'b0;
  logic [MEM_AW-1:0] ld_addr = '0;
  logic [7:0] ld_data = '0;
  localparam logic [7:0] STATUS = 8'h5A;

  always #2.5 clk_i = ~clk_i;

  flash_fe uut (
    .clk_i, .rst_ni, .sck_i(sck), .cs_ni(cs_n), .si_i(si), .so_o, .so_oe_o,
    .busy_i(busy), .status_i(STATUS), .dp_o, .wr_req_o, .wr_op_o, .wr_addr_o,
    .wr_bytes_o, .ld_en_i(ld_en), .ld_addr_i(ld_addr), .ld_data_i(ld_data)
  );

  typedef struct packed {
    logic        mode3;
    logic [2:0]  pre;
    logic [39:0] hdr;
    logic [2:0]  ndata;
    logic [31:0] exp;
  } vec_t;

  // memory preload: byte i = 7*i+3
  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 3'd4, 40'h03_000010_00, 3'd4, 32'h737A8188},  // R1 R2 mode 0
    '{1'b1, 3'd4, 40'h03_00003C_00, 3'd4, 32'hA7AEB5BC},  // R1 R2 mode 3
    '{1'b0, 3'd4, 40'h03_3FFFFE_00, 3'd4, 32'hFFFF030A},  // R2 wrap, erased window
    '{1'b1, 3'd5, 40'h0B_000005_00, 3'd4, 32'h262D343B},  // R3
    '{1'b1, 3'd1, 40'h9F_000000_00, 3'd3, 32'h01021500},  // R5
    '{1'b0, 3'd1, 40'h05_000000_00, 3'd2, 32'h5A5A0000},  // R4
    '{1'b0, 3'd4, 40'hAB_000000_00, 3'd2, 32'h15150000}   // R6
  };

  int checks = 0, fails = 0, req_cnt = 0;
  bit done = 1'b0;
  logic [2:0] last_op;
  logic [ARRAY_AW-1:0] last_addr;
  logic [CNT_W-4:0] last_bytes;

  always @(posedge clk_i) if (rst_ni && wr_req_o) begin
    req_cnt++;
    last_op = wr_op_o;
    last_addr = wr_addr_o;
    last_bytes = wr_bytes_o;
  end

  function automatic string vtag(input int v);
    case (v)
      0, 1: return "R1 R2";
      2: return "R2";
      3: return "R3";
      4: return "R5";
      5: return "R4";
      default: return "R6";
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic xfer(input logic m3, input int nbits, input logic [127:0] mosi, input int hbits,
                      output logic [127:0] miso, output int oe_h, output int oe_d);
    miso = '0; oe_h = 0; oe_d = 0;
    @(negedge clk_i); sck = m3;
    repeat (2) @(negedge clk_i);
    cs_n = 1'b0;
    repeat (2) @(negedge clk_i);
    for (int i = 0; i < nbits; i++) begin
      sck = 1'b0; si = mosi[127-i];
      repeat (2) @(negedge clk_i);
      miso[127-i] = so_o;
      if (so_oe_o) begin
        if (i < hbits) oe_h++; else oe_d++;
      end
      sck = 1'b1;
      repeat (2) @(negedge clk_i);
    end
    if (!m3) sck = 1'b0;
    repeat (2) @(negedge clk_i);
    cs_n = 1'b1;
    repeat (4) @(negedge clk_i);
  endtask

  logic [127:0] mi, sh;
  int oh, od, hb, nb, rc;
  logic [31:0] got, mask;

  initial begin
    repeat (3) @(negedge clk_i);
    // R11 reset state
    check(so_oe_o == 1'b0, "R11 oe", 32'(so_oe_o), 0);
    check(wr_req_o == 1'b0, "R11 req", 32'(wr_req_o), 0);
    check(dp_o == 1'b0, "R11 dp", 32'(dp_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    for (int a = 0; a < (1 << MEM_AW); a++) begin
      ld_en = 1'b1; ld_addr = MEM_AW'(a); ld_data = 8'(a * 7 + 3);
      @(negedge clk_i);
    end
    ld_en = 1'b0;

    for (int v = 0; v < NV; v++) begin
      hb = int'(VECS[v].pre) * 8;
      nb = hb + int'(VECS[v].ndata) * 8;
      xfer(VECS[v].mode3, nb, {VECS[v].hdr, 88'h0}, hb, mi, oh, od);
      sh = mi << hb;
      mask = ~(32'hFFFF_FFFF >> (int'(VECS[v].ndata) * 8));
      got = sh[127:96] & mask;
      check(got == VECS[v].exp, vtag(v), got, VECS[v].exp);
      check(oh == 0, "R10 header oe", 32'(oh), 0);
      check(od == int'(VECS[v].ndata) * 8, "R10 data oe", 32'(od), 32'(VECS[v].ndata) * 8);
      check(so_oe_o == 1'b0, "R10 deselect oe", 32'(so_oe_o), 0);
    end

    // R8 page program, 6 bytes
    rc = req_cnt;
    xfer(1'b0, 48, {8'h02, 24'h000123, 16'hABCD, 80'h0}, 48, mi, oh, od);
    check(req_cnt == rc + 1, "R8 pp req", 32'(req_cnt - rc), 1);
    check(last_op == 3'd3, "R8 pp op", 32'(last_op), 3);
    check(last_addr == 22'h000123, "R8 pp addr", 32'(last_addr), 32'h123);
    check(last_bytes == 9'd6, "R8 pp bytes", 32'(last_bytes), 6);
    // R8 sector erase with 33 bits: discarded
    rc = req_cnt;
    xfer(1'b1, 33, {8'hD8, 24'h010000, 96'h0}, 33, mi, oh, od);
    check(req_cnt == rc, "R8 odd bits", 32'(req_cnt - rc), 0);
    // R8 write enable, mode 3
    xfer(1'b1, 8, {8'h06, 120'h0}, 8, mi, oh, od);
    check(req_cnt == rc + 1 && last_op == 3'd0 && last_bytes == 9'd1, "R8 wren",
          {last_op, 20'h0, last_bytes}, {3'd0, 20'h0, 9'd1});

    // R9 busy suppression
    busy = 1'b1;
    xfer(1'b0, 64, {8'h03, 24'h000010, 96'h0}, 32, mi, oh, od);
    check(od == 0, "R9 read busy", 32'(od), 0);
    rc = req_cnt;
    xfer(1'b0, 32, {8'hD8, 24'h000000, 96'h0}, 32, mi, oh, od);
    check(req_cnt == rc, "R9 erase busy", 32'(req_cnt - rc), 0);
    xfer(1'b0, 16, {8'h05, 120'h0}, 8, mi, oh, od);
    check(mi[119:112] == STATUS && od == 8, "R4 status busy", 32'(mi[119:112]), 32'(STATUS));
    xfer(1'b0, 8, {8'hB9, 120'h0}, 8, mi, oh, od);
    check(dp_o == 1'b0, "R9 dp busy", 32'(dp_o), 0);
    busy = 1'b0;

    // R7 deep power-down
    xfer(1'b0, 9, {8'hB9, 120'h0}, 9, mi, oh, od);
    check(dp_o == 1'b0, "R7 dp 9 bits", 32'(dp_o), 0);
    xfer(1'b1, 8, {8'hB9, 120'h0}, 8, mi, oh, od);
    check(dp_o == 1'b1, "R7 dp enter", 32'(dp_o), 1);
    xfer(1'b0, 64, {8'h03, 24'h000010, 96'h0}, 32, mi, oh, od);
    check(od == 0, "R7 read in dp", 32'(od), 0);
    xfer(1'b0, 32, {8'h9F, 120'h0}, 8, mi, oh, od);
    check(od == 0, "R7 id in dp", 32'(od), 0);
    xfer(1'b0, 16, {8'h05, 120'h0}, 8, mi, oh, od);
    check(od == 0, "R4 status in dp", 32'(od), 0);
    rc = req_cnt;
    xfer(1'b0, 8, {8'h06, 120'h0}, 8, mi, oh, od);
    check(req_cnt == rc, "R7 wren in dp", 32'(req_cnt - rc), 0);

    // R6 signature while busy in dp, then clean release
    busy = 1'b1;
    xfer(1'b0, 48, {8'hAB, 120'h0}, 32, mi, oh, od);
    check(od == 0 && dp_o == 1'b1, "R6 sig busy", {31'h0, dp_o}, 1);
    busy = 1'b0;
    xfer(1'b1, 48, {8'hAB, 120'h0}, 32, mi, oh, od);
    check(mi[95:80] == 16'h1515 && od == 16, "R6 sig data", 32'(mi[95:80]), 32'h1515);
    check(dp_o == 1'b0, "R6 dp exit", 32'(dp_o), 0);
    xfer(1'b0, 40, {8'h03, 24'h000001, 96'h0}, 32, mi, oh, od);
    check(mi[95:88] == 8'h0A, "R2 read after release", 32'(mi[95:88]), 32'h0A);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    done = 1'b1;
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule